// File: doc/BRIEF.md
# Transactional Memory Conflict Tracker

This block sits next to a small first-level data cache and keeps the speculative state of one hardware transaction. The core sends plain loads, plain stores and three transaction commands (begin, commit, abort) on one request channel. A two-bit subtype field picks the command. While a transaction is open, every line the core reads or writes is marked in a per-line read bit or write bit.

Incoming coherence traffic and cache evictions are compared against those bits. An invalidation of any tracked line fails the transaction. So does a read by another requester to a line the transaction has written, and so does the eviction of a tracked line. The first cause is kept as a failure reason. After a failure, core loads and stores no longer reach the cache and are answered with a failed response that carries the reason.

Commit publishes the speculative writes. Abort clears the tracking state and names, for one cycle, every line that must be invalidated because it was written speculatively.

Top module: `htm_conflict_tracker`

## Requirements
- R1: After reset the tracker is out of transactional mode. All read bits and write bits are zero. `rsp_valid_o`, `publish_o` and `inval_mask_o` are zero.
- R2: A request with `req_write`=0 and `req_cmd`=1 (begin) opens transactional mode, and `tx_active_o` is high one cycle later. `req_cmd` is ignored when `req_write`=1, so such a request is a plain store. A begin while the mode is already open changes nothing.
- R3: In transactional mode, a plain load (`req_write`=0, `req_cmd`=0) sets the read bit of `req_line`, and a store sets its write bit; `rd_set_o`/`wr_set_o` bit n is line n, visible one cycle later. Outside the mode both vectors stay zero, `cache_access_o` follows every load and store, and no response is failed.
- R4: An invalidation (`snp_valid`=1, `snp_inv`=1) to a line whose read or write bit is set fails the transaction with reason 1. An invalidation to an untracked line has no effect.
- R5: A remote read (`snp_valid`=1, `snp_inv`=0) to a line whose write bit is set fails the transaction with reason 2. A remote read to a line with only its read bit set, or to an untracked line, has no effect.
- R6: An eviction (`evict_valid`=1) of a line whose read or write bit is set fails the transaction with reason 3. Evicting an untracked line has no effect.
- R7: Once the transaction has failed, each load and store leaves `cache_access_o` low in its own cycle and changes no read or write bit. It is answered with `rsp_failed_o`=1 and `rsp_reason_o` equal to the stored reason.
- R8: An abort (`req_cmd`=3) in transactional mode drives `inval_mask_o` for one cycle with the write bits held just before it. It clears all bits, the failed status and the reason, and leaves the mode, all within one cycle.
- R9: A commit (`req_cmd`=2) on a transaction that has not failed pulses `publish_o` for one cycle. It clears all bits, leaves the mode and keeps `inval_mask_o` zero. Outside the mode a commit publishes nothing.
- R10: A commit on a failed transaction gets a failed response with the stored reason. It does not publish, and the tracker stays in the mode until an abort.
- R11: The reason stays at the first failure cause. Later conflicts before the abort do not change it.
- R12: Every request is answered by `rsp_valid_o`=1 exactly one cycle later, and `rsp_valid_o` is 0 after a cycle with no request. A command that arrives in the same cycle as a conflict takes precedence over that conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = store, 0 = load or command |
| req_cmd | input | 2 | Subtype for loads: 0 plain, 1 begin, 2 commit, 3 abort |
| req_line | input | IDX_W | Cache line index of the access |
| snp_valid | input | 1 | Coherence request present |
| snp_inv | input | 1 | 1 = invalidation, 0 = remote read |
| snp_line | input | IDX_W | Line index of the coherence request |
| evict_valid | input | 1 | Cache is evicting a line |
| evict_line | input | IDX_W | Line index being evicted |
| cache_access_o | output | 1 | Request may access the cache this cycle |
| rsp_valid_o | output | 1 | Response to the previous cycle's request |
| rsp_failed_o | output | 1 | Response carries the transaction-failed flag |
| rsp_reason_o | output | 2 | Failure reason: 0 none, 1 invalidation, 2 remote read, 3 capacity |
| tx_active_o | output | 1 | Transactional mode flag |
| publish_o | output | 1 | One-cycle pulse: speculative writes become visible |
| inval_mask_o | output | NUM_LINES | One-cycle mask of lines to invalidate on abort |
| rd_set_o | output | NUM_LINES | Per-line read bits |
| wr_set_o | output | NUM_LINES | Per-line write bits |

## Verification
For every pair of tracked line and coherence target, the bench sweeps invalidations, remote reads and evictions. It checks that only tracked lines trigger a failure and that each cause yields its own reason. A detector that checked the wrong set bit would fail on untracked lines or miss real conflicts. An abort that cleared the wrong bits would put the wrong lines in the invalidation mask.

Directed sequences cover three further cases:
- a commit after a failure, which a careless design would publish;
- a second conflict after the first, which would overwrite the reason;
- stores carrying command bits, which a decoder that ignored the write flag would mistake for an abort.

// File: rtl/htm_pkg.sv
package htm_pkg;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_BEGIN  = 2'd1,
        CMD_COMMIT = 2'd2,
        CMD_ABORT  = 2'd3
    } htm_cmd_e;

    typedef enum logic [1:0] {
        RSN_NONE     = 2'd0,
        RSN_INVAL    = 2'd1,
        RSN_RREAD    = 2'd2,
        RSN_CAPACITY = 2'd3
    } htm_reason_e;

endpackage

// File: rtl/htm_set_array.sv
module htm_set_array #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic                 set_wr,
    input  logic [IDX_W-1:0]     set_line,
    input  logic                 clr_all,
    output logic [NUM_LINES-1:0] rd_set,
    output logic [NUM_LINES-1:0] wr_set
);

    typedef struct packed {
        logic [NUM_LINES-1:0] rd;
        logic [NUM_LINES-1:0] wr;
    } sets_t;

    sets_t sets_d, sets_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic hit_d;
        always_comb begin
            hit_d = set_en && (set_line == IDX_W'(g));
            if (clr_all) begin
                sets_d.rd[g] = 1'b0;
                sets_d.wr[g] = 1'b0;
            end else begin
                sets_d.rd[g] = sets_q.rd[g] | (hit_d & ~set_wr);
                sets_d.wr[g] = sets_q.wr[g] | (hit_d & set_wr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sets_q <= '0;
        else        sets_q <= sets_d;
    end

    assign rd_set = sets_q.rd;
    assign wr_set = sets_q.wr;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (rd_set == '0) && (wr_set == '0)); // R8

    AST_SET_MARKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_all && set_wr) |=> wr_set[$past(set_line)]); // R3

endmodule

// File: rtl/htm_fail_detect.sv
module htm_fail_detect
    import htm_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] rd_set,
    input  logic [NUM_LINES-1:0] wr_set,
    input  logic                 snp_valid,
    input  logic                 snp_inv,
    input  logic [IDX_W-1:0]     snp_line,
    input  logic                 evict_valid,
    input  logic [IDX_W-1:0]     evict_line,
    output logic                 hit,
    output htm_reason_e          reason
);

    logic snp_rd, snp_wr, ev_rd, ev_wr;

    always_comb begin
        snp_rd = rd_set[snp_line];
        snp_wr = wr_set[snp_line];
        ev_rd  = rd_set[evict_line];
        ev_wr  = wr_set[evict_line];
        hit    = 1'b0;
        reason = RSN_NONE;
        if (snp_valid && snp_inv && (snp_rd || snp_wr)) begin
            hit    = 1'b1;
            reason = RSN_INVAL;
        end else if (snp_valid && !snp_inv && snp_wr) begin
            hit    = 1'b1;
            reason = RSN_RREAD;
        end else if (evict_valid && (ev_rd || ev_wr)) begin
            hit    = 1'b1;
            reason = RSN_CAPACITY;
        end
    end

    always_comb begin
        if (hit) begin
            AST_HIT_HAS_REASON: assert (reason != RSN_NONE); // R4
        end
    end

endmodule

// File: rtl/htm_conflict_tracker.sv
module htm_conflict_tracker
    import htm_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [1:0]           req_cmd,
    input  logic [IDX_W-1:0]     req_line,
    input  logic                 snp_valid,
    input  logic                 snp_inv,
    input  logic [IDX_W-1:0]     snp_line,
    input  logic                 evict_valid,
    input  logic [IDX_W-1:0]     evict_line,
    output logic                 cache_access_o,
    output logic                 rsp_valid_o,
    output logic                 rsp_failed_o,
    output logic [1:0]           rsp_reason_o,
    output logic                 tx_active_o,
    output logic                 publish_o,
    output logic [NUM_LINES-1:0] inval_mask_o,
    output logic [NUM_LINES-1:0] rd_set_o,
    output logic [NUM_LINES-1:0] wr_set_o
);

    typedef struct packed {
        logic                 active;
        logic                 failed;
        htm_reason_e          reason;
        logic                 rsp_valid;
        logic                 rsp_failed;
        htm_reason_e          rsp_reason;
        logic                 publish;
        logic [NUM_LINES-1:0] inval_mask;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    htm_cmd_e             cmd;
    logic                 is_mem, is_cmd, failed_now;
    logic                 set_en, clr_all;
    logic                 det_hit;
    htm_reason_e          det_reason;
    logic [NUM_LINES-1:0] rd_set, wr_set;

    htm_set_array #(.NUM_LINES(NUM_LINES)) u_sets (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (set_en),
        .set_wr   (req_write),
        .set_line (req_line),
        .clr_all  (clr_all),
        .rd_set   (rd_set),
        .wr_set   (wr_set)
    );

    htm_fail_detect #(.NUM_LINES(NUM_LINES)) u_detect (
        .rd_set      (rd_set),
        .wr_set      (wr_set),
        .snp_valid   (snp_valid),
        .snp_inv     (snp_inv),
        .snp_line    (snp_line),
        .evict_valid (evict_valid),
        .evict_line  (evict_line),
        .hit         (det_hit),
        .reason      (det_reason)
    );

    always_comb begin
        cmd        = htm_cmd_e'(req_cmd);
        is_mem     = req_valid && (req_write || cmd == CMD_NONE);
        is_cmd     = req_valid && !req_write && cmd != CMD_NONE;
        failed_now = ctrl_q.active && ctrl_q.failed;
        set_en     = is_mem && ctrl_q.active && !ctrl_q.failed;
        clr_all    = 1'b0;

        ctrl_d            = ctrl_q;
        ctrl_d.rsp_valid  = req_valid;
        ctrl_d.rsp_failed = 1'b0;
        ctrl_d.rsp_reason = RSN_NONE;
        ctrl_d.publish    = 1'b0;
        ctrl_d.inval_mask = '0;

        if (is_mem && failed_now) begin
            ctrl_d.rsp_failed = 1'b1;
            ctrl_d.rsp_reason = ctrl_q.reason;
        end

        // first conflict only; reason stays sticky
        if (ctrl_q.active && !ctrl_q.failed && det_hit) begin
            ctrl_d.failed = 1'b1;
            ctrl_d.reason = det_reason;
        end

        // commands override a same-cycle conflict
        if (is_cmd && cmd == CMD_BEGIN && !ctrl_q.active) begin
            ctrl_d.active = 1'b1;
            ctrl_d.failed = 1'b0;
            ctrl_d.reason = RSN_NONE;
        end
        if (is_cmd && cmd == CMD_COMMIT && ctrl_q.active) begin
            if (ctrl_q.failed) begin
                ctrl_d.rsp_failed = 1'b1;
                ctrl_d.rsp_reason = ctrl_q.reason;
            end else begin
                ctrl_d.publish = 1'b1;
                ctrl_d.active  = 1'b0;
                ctrl_d.failed  = 1'b0;
                ctrl_d.reason  = RSN_NONE;
                clr_all        = 1'b1;
            end
        end
        if (is_cmd && cmd == CMD_ABORT && ctrl_q.active) begin
            ctrl_d.inval_mask = wr_set;
            ctrl_d.active     = 1'b0;
            ctrl_d.failed     = 1'b0;
            ctrl_d.reason     = RSN_NONE;
            clr_all           = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign cache_access_o = is_mem && !failed_now;
    assign rsp_valid_o    = ctrl_q.rsp_valid;
    assign rsp_failed_o   = ctrl_q.rsp_failed;
    assign rsp_reason_o   = ctrl_q.rsp_reason;
    assign tx_active_o    = ctrl_q.active;
    assign publish_o      = ctrl_q.publish;
    assign inval_mask_o   = ctrl_q.inval_mask;
    assign rd_set_o       = rd_set;
    assign wr_set_o       = wr_set;

    AST_IDLE_SETS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active_o |-> (rd_set_o == '0) && (wr_set_o == '0)); // R3

    AST_FAILED_RSP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mem && failed_now) |=> rsp_failed_o && (rsp_reason_o != 2'd0)); // R7

    AST_FAILED_SETS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (is_mem && failed_now) |=> $stable(rd_set_o) && $stable(wr_set_o)); // R7

    AST_ABORT_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && cmd == CMD_ABORT && tx_active_o)
        |=> (inval_mask_o == $past(wr_set_o)) && !tx_active_o); // R8

    AST_COMMIT_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && cmd == CMD_COMMIT && tx_active_o && !failed_now)
        |=> publish_o && (inval_mask_o == '0) && !tx_active_o); // R9

    AST_COMMIT_FAILED: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && cmd == CMD_COMMIT && failed_now)
        |=> !publish_o && rsp_failed_o && tx_active_o); // R10

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid_o); // R12

endmodule

// File: tb/htm_conflict_tracker_tb.sv
module htm_conflict_tracker_tb;

    localparam int NL = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]    req_cmd = 2'd0;
    logic [IW-1:0] req_line = '0;
    logic          snp_valid = 1'b0, snp_inv = 1'b0;
    logic [IW-1:0] snp_line = '0;
    logic          evict_valid = 1'b0;
    logic [IW-1:0] evict_line = '0;
    logic          cache_access_o, rsp_valid_o, rsp_failed_o, tx_active_o, publish_o;
    logic [1:0]    rsp_reason_o;
    logic [NL-1:0] inval_mask_o, rd_set_o, wr_set_o;

    int  checks = 0;
    int  errors = 0;
    logic last_access;

    always #2.5 clk = ~clk;

    htm_conflict_tracker #(.NUM_LINES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_cmd(req_cmd), .req_line(req_line),
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_line(snp_line),
        .evict_valid(evict_valid), .evict_line(evict_line),
        .cache_access_o(cache_access_o), .rsp_valid_o(rsp_valid_o),
        .rsp_failed_o(rsp_failed_o), .rsp_reason_o(rsp_reason_o),
        .tx_active_o(tx_active_o), .publish_o(publish_o),
        .inval_mask_o(inval_mask_o), .rd_set_o(rd_set_o), .wr_set_o(wr_set_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic finish_cycle();
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0; req_cmd = 2'd0;
        snp_valid = 1'b0; evict_valid = 1'b0;
    endtask

    task automatic req(input logic w, input logic [1:0] c, input int line);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_cmd = c; req_line = IW'(line);
        #1 last_access = cache_access_o;
        finish_cycle();
    endtask

    task automatic snoop(input logic inv, input int line);
        @(negedge clk);
        snp_valid = 1'b1; snp_inv = inv; snp_line = IW'(line);
        finish_cycle();
    endtask

    task automatic evict(input int line);
        @(negedge clk);
        evict_valid = 1'b1; evict_line = IW'(line);
        finish_cycle();
    endtask

    task automatic idle();
        @(negedge clk);
        finish_cycle();
    endtask

    // kind: 0 invalidation, 1 remote read, 2 eviction
    task automatic sweep(input int kind);
        for (int i = 0; i < NL; i++) begin
            for (int j = 0; j < NL; j++) begin
                int  w;
                logic exp_f;
                logic [1:0] exp_r;
                w = (i + 3) % NL;
                req(1'b0, 2'd1, 0);
                req(1'b0, 2'd0, i);
                req(1'b1, 2'd0, w);
                if (kind == 0 && j == 0) begin
                    chk("R3 read bit", 32'(rd_set_o), 32'(1 << i));
                    chk("R3 write bit", 32'(wr_set_o), 32'(1 << w));
                end
                case (kind)
                    0: begin snoop(1'b1, j); exp_f = (j == i) || (j == w); exp_r = 2'd1; end
                    1: begin snoop(1'b0, j); exp_f = (j == w); exp_r = 2'd2; end
                    default: begin evict(j); exp_f = (j == i) || (j == w); exp_r = 2'd3; end
                endcase
                req(1'b0, 2'd0, i);
                if (kind == 0) begin
                    chk("R4 invalidation fail flag", 32'(rsp_failed_o), 32'(exp_f));
                    chk("R4 invalidation reason", 32'(rsp_reason_o), exp_f ? 32'(exp_r) : 0);
                end else if (kind == 1) begin
                    chk("R5 remote read fail flag", 32'(rsp_failed_o), 32'(exp_f));
                    chk("R5 remote read reason", 32'(rsp_reason_o), exp_f ? 32'(exp_r) : 0);
                end else begin
                    chk("R6 eviction fail flag", 32'(rsp_failed_o), 32'(exp_f));
                    chk("R6 eviction reason", 32'(rsp_reason_o), exp_f ? 32'(exp_r) : 0);
                end
                chk("R7 access gated after failure", 32'(last_access), 32'(!exp_f));
                req(1'b0, 2'd3, 0);
                chk("R8 abort invalidation mask", 32'(inval_mask_o), 32'(1 << w));
                chk("R8 abort leaves mode", 32'(tx_active_o), 0);
                chk("R8 abort clears sets", 32'({rd_set_o, wr_set_o}), 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 mode after reset", 32'(tx_active_o), 0);
        chk("R1 sets after reset", 32'({rd_set_o, wr_set_o}), 0);
        chk("R1 rsp_valid after reset", 32'(rsp_valid_o), 0);
        chk("R1 publish/inval after reset", 32'({publish_o, inval_mask_o}), 0);

        // R3 outside mode: pass through, no tracking
        req(1'b0, 2'd0, 5);
        chk("R3 idle load access", 32'(last_access), 1);
        chk("R12 response valid", 32'(rsp_valid_o), 1);
        chk("R3 idle load not failed", 32'(rsp_failed_o), 0);
        req(1'b1, 2'd0, 2);
        chk("R3 idle store access", 32'(last_access), 1);
        chk("R3 idle sets stay zero", 32'({rd_set_o, wr_set_o}), 0);
        snoop(1'b1, 2);
        req(1'b0, 2'd2, 0);
        chk("R9 idle commit no publish", 32'(publish_o), 0);
        req(1'b0, 2'd3, 0);
        chk("R8 idle abort no mask", 32'(inval_mask_o), 0);
        idle();
        chk("R12 no request no response", 32'(rsp_valid_o), 0);

        // R2 begin and store with command bits
        req(1'b0, 2'd1, 0);
        chk("R2 begin opens mode", 32'(tx_active_o), 1);
        chk("R2 begin response clean", 32'(rsp_failed_o), 0);
        req(1'b1, 2'd3, 1);
        chk("R2 store with abort bits is a store", 32'(wr_set_o), 32'h02);
        chk("R2 store with abort bits keeps mode", 32'(tx_active_o), 1);
        req(1'b1, 2'd0, 4);
        req(1'b0, 2'd0, 6);
        req(1'b0, 2'd1, 0);
        chk("R2 second begin keeps sets", 32'({rd_set_o, wr_set_o}), 32'h4012);

        // R9 commit success
        req(1'b0, 2'd2, 0);
        chk("R9 commit publishes", 32'(publish_o), 1);
        chk("R9 commit no invalidation", 32'(inval_mask_o), 0);
        chk("R9 commit leaves mode", 32'(tx_active_o), 0);
        chk("R9 commit clears sets", 32'({rd_set_o, wr_set_o}), 0);
        idle();
        chk("R9 publish is one pulse", 32'(publish_o), 0);

        // R5 / R11 / R7 / R10 directed
        req(1'b0, 2'd1, 0);
        req(1'b1, 2'd0, 2);
        req(1'b0, 2'd0, 5);
        snoop(1'b0, 5);
        req(1'b0, 2'd0, 5);
        chk("R5 remote read of read-only line harmless", 32'(rsp_failed_o), 0);
        snoop(1'b0, 2);
        snoop(1'b1, 5);
        req(1'b1, 2'd0, 7);
        chk("R7 failed store no access", 32'(last_access), 0);
        chk("R11 first reason kept", 32'(rsp_reason_o), 2);
        chk("R7 failed store sets frozen", 32'(wr_set_o), 32'h04);
        evict(2);
        req(1'b0, 2'd2, 0);
        chk("R10 failed commit flagged", 32'(rsp_failed_o), 1);
        chk("R10 failed commit reason", 32'(rsp_reason_o), 2);
        chk("R10 failed commit no publish", 32'(publish_o), 0);
        chk("R10 failed commit stays in mode", 32'(tx_active_o), 1);
        req(1'b0, 2'd3, 0);
        chk("R8 abort mask after failure", 32'(inval_mask_o), 32'h04);
        idle();
        chk("R8 mask is one pulse", 32'(inval_mask_o), 0);
        req(1'b0, 2'd0, 3);
        chk("R8 failure cleared by abort", 32'({rsp_failed_o, rsp_reason_o}), 0);

        // sweeps over every tracked line and every target line
        sweep(0);
        sweep(1);
        sweep(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule